// File: doc/BRIEF.md
# Card-Presence Debounce and Interrupt Filter

This block conditions the card-detect contact of each card slot. The raw contact level is synchronized, mapped through a per-slot polarity choice into a "card seen" level, and accepted as the new slot state only after a programmable run of identical consecutive samples. Each accepted change raises a sticky per-slot event flag. Each confirmed removal also issues a one-cycle request to the slot's deactivation sequencer.

The interrupt output is active low and is meant for a wire that other devices share. It is pulled low while any slot that is not masked holds its flag. When a slot runs unfiltered, an insertion also pulls it low straight from the contact, with no clock edge needed, so a sleeping host with its clock stopped can be woken. A masked slot still records its events but never drives the wire. Software can raise a flag on purpose through a strobe and clears it with a read strobe.

Top module: `card_detect_filter`

## Requirements
- R1: After synchronous reset every slot reports no card, its flag is clear, its removal request is low and `irq_n` is high.
- R2: The filter select `filt_sel` maps code 0 to 1 sample and code k (1..7) to 2^(k+1) samples, so codes 6 and 7 give 128 and 256. After the contact settles, the status changes on the (2+N)-th rising edge: 2 synchronizer stages plus N samples.
- R3: With `det_pol`=1 a high contact means a card is present. With `det_pol`=0 a low contact means a card is present.
- R4: `card_present` is 1 while a card is accepted and 0 otherwise. `card_flag` sets on the same edge as any change of `card_present`, for insertion and for removal.
- R5: A sample that agrees with the current accepted state restarts the run count from zero, so a shorter glitch never changes the status.
- R6: With `filt_sel`=0 and the slot not masked, a contact that shows a card while the slot reports none pulls `irq_n` low at once, without any clock edge.
- R7: With `irq_dis`=1 the slot's flag and status still update, but that slot never pulls `irq_n` low.
- R8: `irq_n` is low while any unmasked flag is set, and it returns high only when all unmasked flags are clear.
- R9: `flag_set` sets the flag and `flag_rd_clr` clears it on the next edge. When a set (by the strobe or by a status change) and a clear land on the same edge, the flag ends set.
- R10: `deact_req` is high for exactly one cycle, starting at the edge on which `card_present` falls, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_pin | input | NUM_SLOTS | Raw card-detect contact per slot, asynchronous |
| det_pol | input | NUM_SLOTS | 1: high means card present; 0: low means card present |
| filt_sel | input | NUM_SLOTS x 3 | Consecutive-sample count select per slot |
| irq_dis | input | NUM_SLOTS | Keeps the slot from driving the interrupt |
| flag_set | input | NUM_SLOTS | Software strobe that raises the flag |
| flag_rd_clr | input | NUM_SLOTS | Read strobe that clears the flag |
| card_present | output | NUM_SLOTS | Debounced card status |
| card_flag | output | NUM_SLOTS | Sticky insertion/removal event flag |
| deact_req | output | NUM_SLOTS | One-cycle request to deactivate the slot |
| irq_n | output | 1 | Active-low interrupt, 0 means pull the shared line low |

## Verification
The risky coincidence is a read-clear strobe landing on the same edge as a flag set. The bench provokes it twice. In one case the software set and the read clear are strobed together. In the other the clear is timed so that it lands on the exact edge where a removal is accepted, which also checks the removal request in that cycle. In both cases the expected flag after that edge is 1, and the removal request must still pulse for one cycle.

// File: rtl/card_det_pkg.sv
package card_det_pkg;

    // width of the per-slot sample-count select
    localparam int SEL_W = 3;
    // largest run length is 2^(2^SEL_W); counter must hold it
    localparam int CNT_W = (1 << SEL_W) + 1;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_INSERT  = 2'd1,
        EV_EXTRACT = 2'd2
    } pres_ev_t;

    typedef struct packed {
        logic             pol;
        logic [SEL_W-1:0] sel;
        logic             mask;
    } slot_cfg_t;

    // code 0 -> 1 sample, code k -> 2^(k+1) samples
    function automatic logic [CNT_W-1:0] samples_needed(input logic [SEL_W-1:0] sel);
        logic [CNT_W-1:0] one;
        one = CNT_W'(1);
        if (sel == '0) begin
            return one;
        end
        return one << (32'(sel) + 32'd1);
    endfunction

    // map contact level to "card seen"
    function automatic logic card_seen(input logic pin, input logic pol);
        return pol ? pin : ~pin;
    endfunction

endpackage

// File: rtl/cd_sync2.sv
module cd_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cd_debounce.sv
module cd_debounce
    import card_det_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    input  logic [SEL_W-1:0] sel,
    output logic             status,
    output pres_ev_t         ev
);
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_inc;
    logic [CNT_W-1:0] need;
    logic             accept;

    always_comb begin
        need    = samples_needed(sel);
        run_inc = run_cnt + CNT_W'(1);
        accept  = (level != status) && (run_inc >= need);
        ev      = EV_NONE;
        if (accept) begin
            ev = level ? EV_INSERT : EV_EXTRACT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= 1'b0;
            run_cnt <= '0;
        end else if (level == status) begin
            run_cnt <= '0;
        end else if (accept) begin
            status  <= level;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_inc;
        end
    end
endmodule

// File: rtl/cd_slot_flag.sv
module cd_slot_flag
    import card_det_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pres_ev_t ev,
    input  logic     sw_set,
    input  logic     rd_clr,
    output logic     flag,
    output logic     deact
);
    logic raise;

    always_comb begin
        raise = (ev != EV_NONE) || sw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            deact <= 1'b0;
        end else begin
            if (raise) begin
                flag <= 1'b1;
            end else if (rd_clr) begin
                flag <= 1'b0;
            end
            deact <= (ev == EV_EXTRACT);
        end
    end
endmodule

// File: rtl/cd_irq_merge.sv
module cd_irq_merge #(
    parameter int NUM_SLOTS = 2
) (
    input  logic [NUM_SLOTS-1:0] flag,
    input  logic [NUM_SLOTS-1:0] wake,
    input  logic [NUM_SLOTS-1:0] mask,
    output logic                 irq_n
);
    logic [NUM_SLOTS-1:0] pull;

    always_comb begin
        pull  = (flag | wake) & ~mask;
        irq_n = ~(|pull);
    end
endmodule

// File: rtl/card_detect_filter.sv
module card_detect_filter
    import card_det_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SLOTS-1:0]            card_pin,
    input  logic [NUM_SLOTS-1:0]            det_pol,
    input  logic [NUM_SLOTS-1:0][SEL_W-1:0] filt_sel,
    input  logic [NUM_SLOTS-1:0]            irq_dis,
    input  logic [NUM_SLOTS-1:0]            flag_set,
    input  logic [NUM_SLOTS-1:0]            flag_rd_clr,
    output logic [NUM_SLOTS-1:0]            card_present,
    output logic [NUM_SLOTS-1:0]            card_flag,
    output logic [NUM_SLOTS-1:0]            deact_req,
    output logic                            irq_n
);
    logic [NUM_SLOTS-1:0] pin_sync;
    logic [NUM_SLOTS-1:0] wake;
    logic [NUM_SLOTS-1:0] mask_vec;

    cd_sync2 #(.W(NUM_SLOTS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (card_pin),
        .q   (pin_sync)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        slot_cfg_t cfg;
        pres_ev_t  ev;
        logic      seen_sync;
        logic      seen_raw;

        always_comb begin
            cfg.pol     = det_pol[i];
            cfg.sel     = filt_sel[i];
            cfg.mask    = irq_dis[i];
            seen_sync   = card_seen(pin_sync[i], cfg.pol);
            seen_raw    = card_seen(card_pin[i], cfg.pol);
            // unfiltered insertion path, needs no clock edge
            wake[i]     = (cfg.sel == '0) && seen_raw && !card_present[i];
            mask_vec[i] = cfg.mask;
        end

        cd_debounce u_deb (
            .clk    (clk),
            .rst    (rst),
            .level  (seen_sync),
            .sel    (cfg.sel),
            .status (card_present[i]),
            .ev     (ev)
        );

        cd_slot_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .ev     (ev),
            .sw_set (flag_set[i]),
            .rd_clr (flag_rd_clr[i]),
            .flag   (card_flag[i]),
            .deact  (deact_req[i])
        );
    end

    cd_irq_merge #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .flag  (card_flag),
        .wake  (wake),
        .mask  (mask_vec),
        .irq_n (irq_n)
    );
endmodule

// File: rtl/card_detect_filter_chk.sv
module card_detect_filter_chk
    import card_det_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_SLOTS-1:0][SEL_W-1:0] filt_sel,
    input logic [NUM_SLOTS-1:0]            irq_dis,
    input logic [NUM_SLOTS-1:0]            card_present,
    input logic [NUM_SLOTS-1:0]            card_flag,
    input logic [NUM_SLOTS-1:0]            deact_req,
    input logic                            irq_n
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        // R4: every status change leaves the flag set
        a_r4_flag_on_change: assert property (@(posedge clk) disable iff (rst)
            (card_present[i] != $past(card_present[i])) |-> card_flag[i]);

        // R10: a falling status issues the removal request
        a_r10_deact_on_fall: assert property (@(posedge clk) disable iff (rst)
            $fell(card_present[i]) |-> deact_req[i]);

        // R10: the request appears only right after a removal
        a_r10_deact_only_fall: assert property (@(posedge clk) disable iff (rst)
            deact_req[i] |-> (!card_present[i] && $past(card_present[i])));

        // R2: with a filtered setting two changes cannot follow back to back
        a_r2_min_spacing: assert property (@(posedge clk) disable iff (rst)
            ((card_present[i] != $past(card_present[i])) && (filt_sel[i] != '0))
            |=> ((filt_sel[i] == '0) || $stable(card_present[i])));
    end

    // R8: an unmasked flag holds the line low
    a_r8_enabled_flag_pulls: assert property (@(posedge clk) disable iff (rst)
        (|(card_flag & ~irq_dis)) |-> !irq_n);

    // R7: with every slot masked the line is released
    a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (&irq_dis) |-> irq_n);
endmodule

bind card_detect_filter card_detect_filter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .filt_sel     (filt_sel),
    .irq_dis      (irq_dis),
    .card_present (card_present),
    .card_flag    (card_flag),
    .deact_req    (deact_req),
    .irq_n        (irq_n)
);

// File: tb/card_detect_filter_tb.sv
module card_detect_filter_tb;
    localparam int N      = 2;
    localparam int F_STAT = 0;
    localparam int F_FLAG = 1;
    localparam int F_DEAC = 2;
    localparam int F_IRQ  = 3;

    logic               clk = 1'b0;
    logic               rst;
    logic [N-1:0]       card_pin;
    logic [N-1:0]       det_pol;
    logic [N-1:0][2:0]  filt_sel;
    logic [N-1:0]       irq_dis;
    logic [N-1:0]       flag_set;
    logic [N-1:0]       flag_rd_clr;
    logic [N-1:0]       card_present;
    logic [N-1:0]       card_flag;
    logic [N-1:0]       deact_req;
    logic               irq_n;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int    due;
        int    slot;
        int    fld;
        logic  exp;
        string req;
    } exp_t;

    exp_t sbq[$];

    card_detect_filter #(.NUM_SLOTS(N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .card_pin     (card_pin),
        .det_pol      (det_pol),
        .filt_sel     (filt_sel),
        .irq_dis      (irq_dis),
        .flag_set     (flag_set),
        .flag_rd_clr  (flag_rd_clr),
        .card_present (card_present),
        .card_flag    (card_flag),
        .deact_req    (deact_req),
        .irq_n        (irq_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic actual_of(int slot, int fld);
        case (fld)
            F_STAT:  return card_present[slot];
            F_FLAG:  return card_flag[slot];
            F_DEAC:  return deact_req[slot];
            default: return irq_n;
        endcase
    endfunction

    // monitor: pops due items and compares them away from the edge
    always @(negedge clk) begin : monitor
        exp_t keep[$];
        logic act;
        #2;
        keep = {};
        foreach (sbq[k]) begin
            if (sbq[k].due == cyc) begin
                act = actual_of(sbq[k].slot, sbq[k].fld);
                checks++;
                if (act !== sbq[k].exp) begin
                    errors++;
                    $display("FAIL %s slot %0d field %0d cycle %0d: actual %b expected %b",
                             sbq[k].req, sbq[k].slot, sbq[k].fld, cyc, act, sbq[k].exp);
                end
            end else if (sbq[k].due < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s slot %0d field %0d: actual missed expected at %0d",
                         sbq[k].req, sbq[k].slot, sbq[k].fld, sbq[k].due);
            end else begin
                keep.push_back(sbq[k]);
            end
        end
        sbq = keep;
    end

    task automatic expect_at(int ofs, int slot, int fld, logic e, string req);
        exp_t it;
        it.due  = cyc + ofs;
        it.slot = slot;
        it.fld  = fld;
        it.exp  = e;
        it.req  = req;
        sbq.push_back(it);
    endtask

    task automatic nxt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_clr(int s);
        flag_rd_clr[s] = 1'b1;
        @(negedge clk);
        flag_rd_clr[s] = 1'b0;
    endtask

    task automatic pulse_set(int s);
        flag_set[s] = 1'b1;
        @(negedge clk);
        flag_set[s] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        rst         = 1'b1;
        card_pin    = '0;
        det_pol     = '1;
        filt_sel    = {3'd1, 3'd1};
        irq_dis     = '0;
        flag_set    = '0;
        flag_rd_clr = '0;
        nxt(4);
        rst = 1'b0;

        // R1 reset state
        expect_at(0, 0, F_STAT, 1'b0, "R1");
        expect_at(0, 0, F_FLAG, 1'b0, "R1");
        expect_at(0, 0, F_DEAC, 1'b0, "R1");
        expect_at(0, 1, F_STAT, 1'b0, "R1");
        expect_at(0, 0, F_IRQ,  1'b1, "R1");
        drain();

        // R2/R4: 4-sample insertion on slot 0
        card_pin[0] = 1'b1;
        expect_at(5, 0, F_STAT, 1'b0, "R2");
        expect_at(5, 0, F_FLAG, 1'b0, "R4");
        expect_at(6, 0, F_STAT, 1'b1, "R2");
        expect_at(6, 0, F_FLAG, 1'b1, "R4");
        expect_at(6, 0, F_IRQ,  1'b0, "R8");
        drain();
        pulse_clr(0);
        expect_at(0, 0, F_FLAG, 1'b0, "R9");
        expect_at(0, 0, F_IRQ,  1'b1, "R8");
        drain();

        // R5: a glitch back to the accepted level restarts the run
        card_pin[0] = 1'b0;
        expect_at(9,  0, F_STAT, 1'b1, "R5");
        expect_at(10, 0, F_STAT, 1'b0, "R5");
        expect_at(10, 0, F_FLAG, 1'b1, "R4");
        expect_at(10, 0, F_DEAC, 1'b1, "R10");
        expect_at(11, 0, F_DEAC, 1'b0, "R10");
        nxt(3);
        card_pin[0] = 1'b1;
        nxt(1);
        card_pin[0] = 1'b0;
        drain();
        pulse_clr(0);
        drain();

        // R6: unfiltered insertion pulls irq_n with no edge
        filt_sel[0] = 3'd0;
        nxt(1);
        card_pin[0] = 1'b1;
        expect_at(0, 0, F_IRQ,  1'b0, "R6");
        expect_at(2, 0, F_STAT, 1'b0, "R6");
        expect_at(3, 0, F_STAT, 1'b1, "R2");
        expect_at(3, 0, F_FLAG, 1'b1, "R4");
        drain();
        pulse_clr(0);
        expect_at(0, 0, F_IRQ, 1'b1, "R8");
        drain();

        // R7: masked slot records but never drives
        irq_dis[1]  = 1'b1;
        filt_sel[1] = 3'd0;
        nxt(1);
        card_pin[1] = 1'b1;
        expect_at(0, 0, F_IRQ,  1'b1, "R7");
        expect_at(3, 1, F_STAT, 1'b1, "R7");
        expect_at(3, 1, F_FLAG, 1'b1, "R7");
        expect_at(4, 0, F_IRQ,  1'b1, "R7");
        drain();

        // R8: shared line held until all unmasked flags are clear
        irq_dis[1] = 1'b0;
        expect_at(0, 0, F_IRQ, 1'b0, "R8");
        drain();
        pulse_set(0);
        expect_at(0, 0, F_FLAG, 1'b1, "R9");
        drain();
        pulse_clr(1);
        expect_at(0, 1, F_FLAG, 1'b0, "R9");
        expect_at(0, 0, F_IRQ,  1'b0, "R8");
        drain();
        pulse_clr(0);
        expect_at(0, 0, F_IRQ, 1'b1, "R8");
        drain();

        // R9: set and clear strobes together leave the flag set
        flag_set[0]    = 1'b1;
        flag_rd_clr[0] = 1'b1;
        nxt(1);
        flag_set[0]    = 1'b0;
        flag_rd_clr[0] = 1'b0;
        expect_at(0, 0, F_FLAG, 1'b1, "R9");
        drain();
        pulse_clr(0);
        drain();

        // R9/R10: removal accepted on the same edge as a read clear
        card_pin[0] = 1'b0;
        expect_at(3, 0, F_STAT, 1'b0, "R10");
        expect_at(3, 0, F_FLAG, 1'b1, "R9");
        expect_at(3, 0, F_DEAC, 1'b1, "R10");
        expect_at(4, 0, F_DEAC, 1'b0, "R10");
        nxt(2);
        flag_rd_clr[0] = 1'b1;
        nxt(1);
        flag_rd_clr[0] = 1'b0;
        drain();
        pulse_clr(0);
        drain();

        // R3: low-means-present polarity
        filt_sel[0] = 3'd1;
        nxt(1);
        det_pol[0] = 1'b0;
        expect_at(3, 0, F_STAT, 1'b0, "R3");
        expect_at(4, 0, F_STAT, 1'b1, "R3");
        expect_at(4, 0, F_FLAG, 1'b1, "R3");
        drain();
        pulse_clr(0);
        drain();
        card_pin[0] = 1'b1;
        expect_at(5, 0, F_STAT, 1'b1, "R3");
        expect_at(6, 0, F_STAT, 1'b0, "R3");
        expect_at(6, 0, F_DEAC, 1'b1, "R10");
        drain();
        pulse_clr(0);
        drain();

        // R5: two stray samples while polarity and pin swap together
        det_pol[0]  = 1'b1;
        card_pin[0] = 1'b0;
        expect_at(8, 0, F_STAT, 1'b0, "R5");
        expect_at(8, 0, F_FLAG, 1'b0, "R5");
        drain();

        // R2: longest setting, 256 samples
        filt_sel[0] = 3'd7;
        nxt(1);
        card_pin[0] = 1'b1;
        expect_at(257, 0, F_STAT, 1'b0, "R2");
        expect_at(258, 0, F_STAT, 1'b1, "R2");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule